// File: doc/BRIEF.md
# Operand Address Resolver for an 8-bit CPU

This sequential unit works out where an instruction's operand lives and what that operand is. A start pulse brings in an addressing-mode code together with the current program counter and the X, Y and accumulator values. The unit then walks its state machine. It reads the operand bytes that follow the opcode, then any pointer bytes the mode calls for, then the data byte at the final address. All of these reads go through a byte-wide port with one cycle of read latency. When the walk is over it raises `done` for one cycle and presents the 16-bit effective address, the operand value and the instruction length in bytes.

The state machine has the states IDLE, OPL_REQ/OPL_CAP (low operand byte), OPH_REQ/OPH_CAP (high operand byte), PTL_REQ/PTL_CAP and PTH_REQ/PTH_CAP (pointer low and high byte), DAT_REQ/DAT_CAP (data byte) and DONE. Each REQ state issues one read and moves to its CAP state, which stores the returned byte. The transitions are as follows:
- IDLE with start goes to OPL_REQ for a mode that has an operand. For any other mode it goes straight to DONE.
- OPL_CAP goes to OPH_REQ for two-byte operands. Otherwise it goes to PTL_REQ for the zero-page pointer modes, to DAT_REQ for the zero-page modes, and to DONE for immediate and branch.
- OPH_CAP goes to PTL_REQ for the indirect mode and to DAT_REQ for the others.
- PTH_CAP goes to DAT_REQ.
- DAT_CAP goes to DONE.
- DONE always returns to IDLE.

Top module: `addr_resolver`

## Requirements
- R1: While reset is high and in the first cycle after it, `done` and `mem_rd` are low.
- R2: Mode codes are 0 implied, 1 accumulator, 2 immediate, 3 zero page, 4 zero page+X, 5 zero page+Y, 6 absolute, 7 absolute+X, 8 absolute+Y, 9 indirect, 10 pre-indexed indirect (X), 11 post-indexed indirect (Y), 12 branch relative, 13 two-byte skip, 14 three-byte skip, and 15 acts as implied. `length` is 1 for codes 0, 1 and 15. It is 2 for codes 2, 3, 4, 5, 10, 11, 12 and 13. It is 3 for codes 6, 7, 8, 9 and 14.
- R3: Accumulator mode returns A as `value` and makes no read. Immediate mode returns the byte at PC+1 and makes one read. Both give an effective address of 0.
- R4: Zero page uses the operand byte as the address. The zero page+X and +Y modes add the index modulo 256, so the upper address byte is always 0. `value` is the byte read at that address.
- R5: Absolute modes take the low byte from PC+1 and the high byte from PC+2. The +X and +Y forms add the index to the full 16-bit address, which may cross pages and wraps modulo 65536.
- R6: Indirect mode reads a 16-bit pointer at the operand address, low byte first and high byte at that address plus 1 (a 16-bit increment). The pointer is the effective address.
- R7: Pre-indexed mode forms (operand+X) mod 256. It reads the pointer low byte there and the high byte at (that+1) mod 256. The pointer is the effective address.
- R8: Post-indexed mode reads a pointer from the zero-page address given by the operand, with the high byte at (operand+1) mod 256. It then adds Y to the 16-bit pointer.
- R9: Branch-relative mode gives PC+2 plus the operand read as a signed 8-bit value, modulo 65536. `value` is 0 and exactly one read is made.
- R10: Implied, the two-byte skip, the three-byte skip and code 15 make no reads and give an effective address of 0 and a `value` of 0.
- R11: Read data is taken one cycle after `mem_rd`. No two reads are in adjacent cycles. `done` is high for exactly one cycle, with no read in that cycle. Read counts per mode: implied-type modes 0, immediate and branch 1, zero-page modes 2, absolute modes 3, pre- and post-indexed 4, indirect 5.
- R12: A start pulse while a resolution is in progress is ignored. The result belongs to the first request, and only one `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a resolution (taken in IDLE only) |
| mode | input | 4 | Addressing-mode code |
| pc | input | 16 | Address of the opcode |
| x_reg | input | 8 | X index value |
| y_reg | input | 8 | Y index value |
| a_reg | input | 8 | Accumulator value |
| mem_rd | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| done | output | 1 | Result valid, one cycle |
| eff_addr | output | 16 | Effective address |
| value | output | 8 | Operand value |
| length | output | 2 | Instruction length in bytes |

## Verification
The checker assumes that the memory returns each byte in the cycle after the request. It also relies on `start` being sampled only in IDLE, so it takes the latched mode as the one that owns each `done` pulse. The bench's memory model is a registered read with exactly that one-cycle latency. The bench holds `mode` and the register inputs steady for the single start cycle, and it issues a second start in mid-run only to confirm that the latched mode stays unchanged.

// File: rtl/ear_pkg.sv
package ear_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        AM_IMPL   = 4'd0,
        AM_ACCU   = 4'd1,
        AM_IMMED  = 4'd2,
        AM_ZP     = 4'd3,
        AM_ZP_X   = 4'd4,
        AM_ZP_Y   = 4'd5,
        AM_ABSO   = 4'd6,
        AM_ABS_X  = 4'd7,
        AM_ABS_Y  = 4'd8,
        AM_INDIR  = 4'd9,
        AM_PRE_X  = 4'd10,
        AM_POST_Y = 4'd11,
        AM_BRANCH = 4'd12,
        AM_SKIP2  = 4'd13,
        AM_SKIP3  = 4'd14
    } amode_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OPL_REQ, ST_OPL_CAP, ST_OPH_REQ, ST_OPH_CAP,
        ST_PTL_REQ, ST_PTL_CAP, ST_PTH_REQ, ST_PTH_CAP,
        ST_DAT_REQ, ST_DAT_CAP, ST_DONE
    } rstate_e;

    // True when the mode reads at least one byte following the opcode
    function automatic logic has_operand(input logic [MODE_W-1:0] m);
        unique case (m)
            AM_IMPL, AM_ACCU, AM_SKIP2, AM_SKIP3: return 1'b0;
            4'd15:                                return 1'b0;
            default:                              return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/ear_mode_info.sv
module ear_mode_info
    import ear_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output logic [1:0]        len,
    output logic              wide_opnd,
    output logic              uses_ptr,
    output logic              reads_data
);
    always_comb begin
        len        = 2'd1;
        wide_opnd  = 1'b0;
        uses_ptr   = 1'b0;
        reads_data = 1'b0;
        unique case (mode)
            AM_IMMED, AM_BRANCH, AM_SKIP2:  len = 2'd2;
            AM_ZP, AM_ZP_X, AM_ZP_Y: begin
                len = 2'd2; reads_data = 1'b1;
            end
            AM_PRE_X, AM_POST_Y: begin
                len = 2'd2; uses_ptr = 1'b1; reads_data = 1'b1;
            end
            AM_ABSO, AM_ABS_X, AM_ABS_Y: begin
                len = 2'd3; wide_opnd = 1'b1; reads_data = 1'b1;
            end
            AM_INDIR: begin
                len = 2'd3; wide_opnd = 1'b1; uses_ptr = 1'b1; reads_data = 1'b1;
            end
            AM_SKIP3: len = 2'd3;
            default:  len = 2'd1;
        endcase
    end
endmodule

// File: rtl/ear_addr_calc.sv
module ear_addr_calc
    import ear_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [AW-1:0]     pc,
    input  logic [DW-1:0]     x_val,
    input  logic [DW-1:0]     y_val,
    input  logic [DW-1:0]     opl,
    input  logic [DW-1:0]     oph,
    input  logic [DW-1:0]     ptl,
    input  logic [DW-1:0]     pth,
    output logic [AW-1:0]     ptr_lo_addr,
    output logic [AW-1:0]     ptr_hi_addr,
    output logic [AW-1:0]     eff_addr
);
    localparam int PAD = AW - DW;

    logic [DW-1:0] zp_base;
    logic [DW-1:0] zp_next;
    logic [AW-1:0] wide_opnd;
    logic [AW-1:0] ptr_word;

    assign wide_opnd = {oph, opl};
    assign ptr_word  = {pth, ptl};
    assign zp_base   = (mode == AM_PRE_X) ? opl + x_val : opl;
    assign zp_next   = zp_base + 1'b1;

    always_comb begin
        if (mode == AM_INDIR) begin
            ptr_lo_addr = wide_opnd;
            ptr_hi_addr = wide_opnd + 1'b1;
        end else begin
            ptr_lo_addr = {{PAD{1'b0}}, zp_base};
            ptr_hi_addr = {{PAD{1'b0}}, zp_next};
        end
    end

    always_comb begin
        unique case (mode)
            AM_ZP:     eff_addr = {{PAD{1'b0}}, opl};
            AM_ZP_X:   eff_addr = {{PAD{1'b0}}, DW'(opl + x_val)};
            AM_ZP_Y:   eff_addr = {{PAD{1'b0}}, DW'(opl + y_val)};
            AM_ABSO:   eff_addr = wide_opnd;
            AM_ABS_X:  eff_addr = wide_opnd + {{PAD{1'b0}}, x_val};
            AM_ABS_Y:  eff_addr = wide_opnd + {{PAD{1'b0}}, y_val};
            AM_INDIR, AM_PRE_X: eff_addr = ptr_word;
            AM_POST_Y: eff_addr = ptr_word + {{PAD{1'b0}}, y_val};
            AM_BRANCH: eff_addr = pc + AW'(2) + {{PAD{opl[DW-1]}}, opl};
            default:   eff_addr = '0;
        endcase
    end
endmodule

// File: rtl/addr_resolver.sv
module addr_resolver
    import ear_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [AW-1:0]     pc,
    input  logic [DW-1:0]     x_reg,
    input  logic [DW-1:0]     y_reg,
    input  logic [DW-1:0]     a_reg,
    output logic              mem_rd,
    output logic [AW-1:0]     mem_addr,
    input  logic [DW-1:0]     mem_rdata,
    output logic              done,
    output logic [AW-1:0]     eff_addr,
    output logic [DW-1:0]     value,
    output logic [1:0]        length
);
    rstate_e           state_q, state_d;
    logic [MODE_W-1:0] mode_q;
    logic [AW-1:0]     pc_q;
    logic [DW-1:0]     x_q, y_q, a_q;
    logic [DW-1:0]     opl_q, oph_q, ptl_q, pth_q, dat_q;
    logic              wide_opnd, uses_ptr, reads_data;
    logic [AW-1:0]     ptr_lo_addr, ptr_hi_addr, ea;

    ear_mode_info u_info (
        .mode       (mode_q),
        .len        (length),
        .wide_opnd  (wide_opnd),
        .uses_ptr   (uses_ptr),
        .reads_data (reads_data)
    );

    ear_addr_calc #(.AW(AW), .DW(DW)) u_calc (
        .mode        (mode_q),
        .pc          (pc_q),
        .x_val       (x_q),
        .y_val       (y_q),
        .opl         (opl_q),
        .oph         (oph_q),
        .ptl         (ptl_q),
        .pth         (pth_q),
        .ptr_lo_addr (ptr_lo_addr),
        .ptr_hi_addr (ptr_hi_addr),
        .eff_addr    (ea)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = has_operand(mode) ? ST_OPL_REQ : ST_DONE;
            ST_OPL_REQ: state_d = ST_OPL_CAP;
            ST_OPL_CAP: begin
                if (wide_opnd)       state_d = ST_OPH_REQ;
                else if (uses_ptr)   state_d = ST_PTL_REQ;
                else if (reads_data) state_d = ST_DAT_REQ;
                else                 state_d = ST_DONE;
            end
            ST_OPH_REQ: state_d = ST_OPH_CAP;
            ST_OPH_CAP: state_d = uses_ptr ? ST_PTL_REQ : ST_DAT_REQ;
            ST_PTL_REQ: state_d = ST_PTL_CAP;
            ST_PTL_CAP: state_d = ST_PTH_REQ;
            ST_PTH_REQ: state_d = ST_PTH_CAP;
            ST_PTH_CAP: state_d = ST_DAT_REQ;
            ST_DAT_REQ: state_d = ST_DAT_CAP;
            ST_DAT_CAP: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register with request latch and byte capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            pc_q    <= '0;
            x_q     <= '0;
            y_q     <= '0;
            a_q     <= '0;
            opl_q   <= '0;
            oph_q   <= '0;
            ptl_q   <= '0;
            pth_q   <= '0;
            dat_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                mode_q <= mode;
                pc_q   <= pc;
                x_q    <= x_reg;
                y_q    <= y_reg;
                a_q    <= a_reg;
            end
            unique case (state_q)
                ST_OPL_CAP: opl_q <= mem_rdata;
                ST_OPH_CAP: oph_q <= mem_rdata;
                ST_PTL_CAP: ptl_q <= mem_rdata;
                ST_PTH_CAP: pth_q <= mem_rdata;
                ST_DAT_CAP: dat_q <= mem_rdata;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = '0;
        done     = (state_q == ST_DONE);
        eff_addr = ea;
        unique case (state_q)
            ST_OPL_REQ: begin mem_rd = 1'b1; mem_addr = pc_q + AW'(1); end
            ST_OPH_REQ: begin mem_rd = 1'b1; mem_addr = pc_q + AW'(2); end
            ST_PTL_REQ: begin mem_rd = 1'b1; mem_addr = ptr_lo_addr; end
            ST_PTH_REQ: begin mem_rd = 1'b1; mem_addr = ptr_hi_addr; end
            ST_DAT_REQ: begin mem_rd = 1'b1; mem_addr = ea; end
            default: ;
        endcase
        if (mode_q == AM_ACCU)       value = a_q;
        else if (mode_q == AM_IMMED) value = opl_q;
        else if (reads_data)         value = dat_q;
        else                         value = '0;
    end
endmodule

// File: rtl/ear_checker.sv
module ear_checker
    import ear_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [MODE_W-1:0] mode_q,
    input logic              busy,
    input logic              done,
    input logic              mem_rd,
    input logic [AW-1:0]     eff_addr,
    input logic [DW-1:0]     value,
    input logic [1:0]        length
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!done && !mem_rd));

    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_no_back_to_back_r11: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    p_done_no_read_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_rd);

    p_zero_page_r4: assert property (@(posedge clk) disable iff (rst)
        (done && (mode_q == AM_ZP || mode_q == AM_ZP_X || mode_q == AM_ZP_Y))
        |-> ((eff_addr >> DW) == '0));

    p_branch_value_r9: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q == AM_BRANCH) |-> (value == '0));

    p_long_forms_r2: assert property (@(posedge clk) disable iff (rst)
        (done && (mode_q == AM_ABSO || mode_q == AM_INDIR || mode_q == AM_SKIP3))
        |-> (length == 2'd3));

    p_skip_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (done && (mode_q == AM_SKIP2 || mode_q == AM_SKIP3 || mode_q == AM_IMPL))
        |-> (eff_addr == '0 && value == '0));

    p_mode_held_r12: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(mode_q));
endmodule

bind addr_resolver ear_checker #(.AW(AW), .DW(DW)) u_ear_checker (
    .clk      (clk),
    .rst      (rst),
    .mode_q   (mode_q),
    .busy     (state_q != ear_pkg::ST_IDLE),
    .done     (done),
    .mem_rd   (mem_rd),
    .eff_addr (eff_addr),
    .value    (value),
    .length   (length)
);

// File: tb/test_addr_resolver.sv
module test_addr_resolver;
    import ear_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [3:0]  mode;
    logic [15:0] pc;
    logic [7:0]  x_reg, y_reg, a_reg;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        done;
    logic [15:0] eff_addr;
    logic [7:0]  value;
    logic [1:0]  length;

    int tests_run  = 0;
    int tests_fail = 0;
    int read_cnt   = 0;
    int cycle_cnt  = 0;

    logic [7:0] mem [logic [15:0]];

    always #10 clk = ~clk;

    addr_resolver i_addr_resolver (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .pc(pc),
        .x_reg(x_reg), .y_reg(y_reg), .a_reg(a_reg),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .done(done), .eff_addr(eff_addr), .value(value), .length(length)
    );

    function automatic logic [7:0] rd(input logic [15:0] a);
        if (mem.exists(a)) return mem[a];
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
    endfunction

    // Registered read with one cycle latency, plus a read counter
    always @(posedge clk) begin
        cycle_cnt <= cycle_cnt + 1;
        if (mem_rd) begin
            mem_rdata <= rd(mem_addr);
            read_cnt  <= read_cnt + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Start one resolution, wait for done, check all outputs and read count
    task automatic resolve(input string req, input logic [3:0] m,
                           input logic [15:0] p, input logic [7:0] xv,
                           input logic [7:0] yv, input logic [7:0] av,
                           input logic [15:0] e_ea, input logic [7:0] e_val,
                           input logic [1:0] e_len, input int e_reads);
        int waited = 0;
        @(negedge clk);
        read_cnt = 0;
        mode = m; pc = p; x_reg = xv; y_reg = yv; a_reg = av; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        chk(req, "done seen", {31'd0, done}, 32'd1);
        chk(req, "eff_addr", {16'd0, eff_addr}, {16'd0, e_ea});
        chk(req, "value", {24'd0, value}, {24'd0, e_val});
        chk(req, "length", {30'd0, length}, {30'd0, e_len});
        chk("R11", "read count", read_cnt, e_reads);
        @(negedge clk);
        chk("R11", "done one cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; mode = '0; pc = '0;
        x_reg = '0; y_reg = '0; a_reg = '0;
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", {31'd0, done}, 32'd0);
        chk("R1", "mem_rd in reset", {31'd0, mem_rd}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "done after reset", {31'd0, done}, 32'd0);
        chk("R1", "mem_rd after reset", {31'd0, mem_rd}, 32'd0);
    endtask

    task automatic t_accu_immed();
        resolve("R3", AM_ACCU, 16'h0700, 8'h01, 8'h02, 8'h9A, 16'h0000, 8'h9A, 2'd1, 0);
        mem[16'h0701] = 8'hE7;
        resolve("R3", AM_IMMED, 16'h0700, 8'h01, 8'h02, 8'h9A, 16'h0000, 8'hE7, 2'd2, 1);
    endtask

    task automatic t_zero_page();
        mem[16'h0301] = 8'h44;
        resolve("R4", AM_ZP, 16'h0300, 8'h20, 8'h90, 8'h00, 16'h0044, rd(16'h0044), 2'd2, 2);
        mem[16'h0301] = 8'hF0;
        resolve("R4", AM_ZP_X, 16'h0300, 8'h20, 8'h90, 8'h00, 16'h0010, rd(16'h0010), 2'd2, 2);
        mem[16'h0301] = 8'h80;
        resolve("R4", AM_ZP_Y, 16'h0300, 8'h20, 8'h90, 8'h00, 16'h0010, rd(16'h0010), 2'd2, 2);
    endtask

    task automatic t_absolute();
        mem[16'h0401] = 8'h34; mem[16'h0402] = 8'h12;
        resolve("R5", AM_ABSO, 16'h0400, 8'h20, 8'h20, 8'h00, 16'h1234, rd(16'h1234), 2'd3, 3);
        mem[16'h0401] = 8'hF0;
        resolve("R5", AM_ABS_X, 16'h0400, 8'h20, 8'h00, 8'h00, 16'h1310, rd(16'h1310), 2'd3, 3);
        mem[16'h0402] = 8'hFF;
        resolve("R5", AM_ABS_Y, 16'h0400, 8'h00, 8'h20, 8'h00, 16'h0010, rd(16'h0010), 2'd3, 3);
    endtask

    task automatic t_indirect();
        mem[16'h0501] = 8'h00; mem[16'h0502] = 8'h60;
        mem[16'h6000] = 8'hCD; mem[16'h6001] = 8'hAB;
        resolve("R6", AM_INDIR, 16'h0500, 8'h00, 8'h00, 8'h00, 16'hABCD, rd(16'hABCD), 2'd3, 5);
        mem[16'h0501] = 8'hFF;
        mem[16'h60FF] = 8'h11; mem[16'h6100] = 8'h22;
        resolve("R6", AM_INDIR, 16'h0500, 8'h00, 8'h00, 8'h00, 16'h2211, rd(16'h2211), 2'd3, 5);
    endtask

    task automatic t_pre_x();
        mem[16'h0601] = 8'hF0;
        mem[16'h00FF] = 8'h78; mem[16'h0000] = 8'h56;
        resolve("R7", AM_PRE_X, 16'h0600, 8'h0F, 8'h00, 8'h00, 16'h5678, rd(16'h5678), 2'd2, 4);
    endtask

    task automatic t_post_y();
        mem[16'h0601] = 8'hFF;
        mem[16'h00FF] = 8'h78; mem[16'h0000] = 8'h56;
        resolve("R8", AM_POST_Y, 16'h0600, 8'h00, 8'h90, 8'h00, 16'h5708, rd(16'h5708), 2'd2, 4);
    endtask

    task automatic t_branch();
        mem[16'h1001] = 8'h10;
        resolve("R9", AM_BRANCH, 16'h1000, 8'h00, 8'h00, 8'h00, 16'h1012, 8'h00, 2'd2, 1);
        mem[16'h1001] = 8'hF0;
        resolve("R9", AM_BRANCH, 16'h1000, 8'h00, 8'h00, 8'h00, 16'h0FF2, 8'h00, 2'd2, 1);
        mem[16'hFFFF] = 8'h05;
        resolve("R9", AM_BRANCH, 16'hFFFE, 8'h00, 8'h00, 8'h00, 16'h0005, 8'h00, 2'd2, 1);
    endtask

    task automatic t_no_operand();
        resolve("R10", AM_IMPL,  16'h2000, 8'h11, 8'h22, 8'h33, 16'h0000, 8'h00, 2'd1, 0);
        resolve("R10", AM_SKIP2, 16'h2000, 8'h11, 8'h22, 8'h33, 16'h0000, 8'h00, 2'd2, 0);
        resolve("R10", AM_SKIP3, 16'h2000, 8'h11, 8'h22, 8'h33, 16'h0000, 8'h00, 2'd3, 0);
        resolve("R2",  4'd15,    16'h2000, 8'h11, 8'h22, 8'h33, 16'h0000, 8'h00, 2'd1, 0);
    endtask

    task automatic t_busy_start();
        int dones = 0;
        @(negedge clk);
        mem[16'h0801] = 8'h00; mem[16'h0802] = 8'h44;
        read_cnt = 0;
        mode = AM_ABSO; pc = 16'h0800; x_reg = 8'h00; y_reg = 8'h00; a_reg = 8'h5E;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        mode = AM_ACCU; pc = 16'h0900; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (done) begin
                dones++;
                chk("R12", "eff_addr of first request", {16'd0, eff_addr}, 32'h4400);
                chk("R12", "value of first request", {24'd0, value}, {24'd0, rd(16'h4400)});
            end
            @(negedge clk);
        end
        chk("R12", "done pulses", dones, 1);
        chk("R12", "reads of first request", read_cnt, 3);
    endtask

    initial begin
        t_reset();
        t_accu_immed();
        t_zero_page();
        t_absolute();
        t_indirect();
        t_pre_x();
        t_post_y();
        t_branch();
        t_no_operand();
        t_busy_start();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_fail);
        $finish;
    end

    initial begin
        wait (cycle_cnt > 100000);
        tests_run++;
        tests_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycle_cnt);
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_fail);
        $finish;
    end
endmodule